// File: doc/BRIEF.md
# DLL Reset Lock Timer

This block holds a twelve-bit mode register for a DDR3 memory model and turns one bit of it into a timed lock window. Software, or a controller model, writes the register with a one-cycle strobe. The write-recovery code in bits 11:9 is decoded into a cycle count and flagged when illegal. Bit 8 requests a DLL reset. That bit clears itself on the next clock edge. Writing it also opens a lock window during which read commands are refused.

The window closes only after a parameterised number of consecutive clock edges (512 by default) with the clock-enable input held high. A low clock-enable during the window restarts the count from the full length. A fresh DLL reset request during the window also restarts it. A read request is answered one cycle later. It gets an accept pulse when reads are allowed, or a reject pulse when they are blocked. A rejected request is dropped and is not held for later.

Top module: `dll_lock_gate`

## Requirements
- R1: After synchronous reset, `mr_q` is 0, `rd_ok` is 1, `rd_accept` and `rd_reject` are 0, `wr_cycles` is 0 and `wr_bad` is 1.
- R2: A write (`mr_wr_en` high at an edge) stores all twelve bits of `mr_wr_data` into `mr_q`, visible right after that edge. Bit 8 of `mr_q` is then cleared at the next edge unless that edge writes it again; all other bits keep their value.
- R3: A write with bit 8 set makes `rd_ok` 0 right after the write edge.
- R4: With `cke` high on every later edge, `rd_ok` returns to 1 right after the LOCK_CYCLES-th edge following the write edge (512 by default), and not before.
- R5: An edge with `cke` low during the window restarts the count. `rd_ok` returns to 1 only after LOCK_CYCLES consecutive edges with `cke` high following the last low edge.
- R6: `wr_cycles` decodes bits 11:9 of the written data as 1→5, 2→6, 3→7, 4→8, 5→10, 6→12, 7→14. Code 0 gives `wr_cycles`=0 and `wr_bad`=1; any other code gives `wr_bad`=0. Both are updated with `mr_q`.
- R7: `rd_req` high at an edge while `rd_ok` is 0 gives `rd_reject`=1 and `rd_accept`=0 for the one cycle after that edge. The request is dropped, so no accept follows later.
- R8: `rd_req` high at an edge while `rd_ok` is 1 gives `rd_accept`=1 and `rd_reject`=0 for the one cycle after that edge.
- R9: A write with bit 8 set during an open window restarts the window from its full length at that write edge.
- R10: A write with bit 8 clear leaves `rd_ok` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mr_wr_en | input | 1 | Mode register write strobe |
| mr_wr_data | input | 12 | Mode register write data |
| cke | input | 1 | Clock enable; must stay high for the window to count |
| rd_req | input | 1 | Read command request |
| rd_ok | output | 1 | Reads allowed (no lock window open) |
| rd_accept | output | 1 | One-cycle pulse: read accepted |
| rd_reject | output | 1 | One-cycle pulse: read refused during lock window |
| wr_cycles | output | 4 | Decoded write-recovery cycles |
| wr_bad | output | 1 | Write-recovery code is illegal |
| mr_q | output | 12 | Current register contents |

## Verification
Every output is registered. The register contents, the decoded recovery value and both read pulses are due right after the edge that samples their inputs. `rd_ok` falls after the write edge. It rises exactly LOCK_CYCLES edges after the last write or low clock-enable edge. The driver computes the cycle at which each result is due from these rules, and files the expected value under that cycle. The monitor compares only at the falling edge of that cycle. This covers the cycle just before the window closes and the cycle it closes. It also includes cycles where a dropped read must not turn into a late accept.

// File: rtl/dlg_pkg.sv
package dlg_pkg;

  localparam int WR_CODE_W = 3;
  localparam int WR_CYC_W  = 4;

  // Write-recovery code to cycle count; 0 means the code is illegal.
  function automatic logic [WR_CYC_W-1:0] wr_code_to_cycles(input logic [WR_CODE_W-1:0] code);
    logic [WR_CYC_W-1:0] c;
    c = WR_CYC_W'(code);
    if (code == '0)
      return '0;
    else if (code <= WR_CODE_W'(4))
      return c + WR_CYC_W'(4);
    else
      return c << 1;
  endfunction

endpackage

// File: rtl/dlg_mode_reg.sv
module dlg_mode_reg
  import dlg_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int DLL_BIT = 8,
  parameter int WR_LSB  = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                dll_start,
  output logic [DATA_W-1:0]   mr_q,
  output logic [WR_CYC_W-1:0] wr_cycles,
  output logic                wr_bad
);

  localparam int WR_MSB = WR_LSB + WR_CODE_W - 1;

  logic [WR_CODE_W-1:0] code_in;

  assign code_in   = wr_data[WR_MSB:WR_LSB];
  assign dll_start = wr_en && wr_data[DLL_BIT];

  // Register storage with a self-clearing request bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      mr_q <= '0;
    end else if (wr_en) begin
      mr_q <= wr_data;
    end else begin
      mr_q[DLL_BIT] <= 1'b0;
    end
  end

  // Decoded recovery value, updated in step with the register.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cycles <= '0;
      wr_bad    <= 1'b1;
    end else if (wr_en) begin
      wr_cycles <= wr_code_to_cycles(code_in);
      wr_bad    <= (code_in == '0);
    end
  end

endmodule

// File: rtl/dlg_lock_cnt.sv
module dlg_lock_cnt #(
  parameter int LOCK_CYCLES = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cke,
  output logic locked
);

  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LOCK_CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy   <= 1'b0;
      locked <= 1'b1;
    end else if (start) begin
      cnt    <= FULL;
      busy   <= 1'b1;
      locked <= 1'b0;
    end else if (busy) begin
      if (!cke) begin
        cnt <= FULL;
      end else if (cnt == ONE) begin
        cnt    <= '0;
        busy   <= 1'b0;
        locked <= 1'b1;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

endmodule

// File: rtl/dlg_read_gate.sv
module dlg_read_gate (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic rd_ok,
  output logic rd_accept,
  output logic rd_reject
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_accept <= 1'b0;
      rd_reject <= 1'b0;
    end else begin
      rd_accept <= rd_req && rd_ok;
      rd_reject <= rd_req && !rd_ok;
    end
  end

endmodule

// File: rtl/dll_lock_gate.sv
module dll_lock_gate
  import dlg_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int DLL_BIT     = 8,
  parameter int WR_LSB      = 9,
  parameter int LOCK_CYCLES = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mr_wr_en,
  input  logic [DATA_W-1:0]   mr_wr_data,
  input  logic                cke,
  input  logic                rd_req,
  output logic                rd_ok,
  output logic                rd_accept,
  output logic                rd_reject,
  output logic [WR_CYC_W-1:0] wr_cycles,
  output logic                wr_bad,
  output logic [DATA_W-1:0]   mr_q
);

  logic dll_start;

  dlg_mode_reg #(
    .DATA_W (DATA_W),
    .DLL_BIT(DLL_BIT),
    .WR_LSB (WR_LSB)
  ) u_mreg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mr_wr_en),
    .wr_data  (mr_wr_data),
    .dll_start(dll_start),
    .mr_q     (mr_q),
    .wr_cycles(wr_cycles),
    .wr_bad   (wr_bad)
  );

  dlg_lock_cnt #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) u_lock (
    .clk   (clk),
    .rst   (rst),
    .start (dll_start),
    .cke   (cke),
    .locked(rd_ok)
  );

  dlg_read_gate u_rgate (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_ok    (rd_ok),
    .rd_accept(rd_accept),
    .rd_reject(rd_reject)
  );

endmodule

// File: rtl/dll_lock_gate_chk.sv
module dll_lock_gate_chk
  import dlg_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int DLL_BIT     = 8,
  parameter int WR_LSB      = 9,
  parameter int LOCK_CYCLES = 512
) (
  input logic                clk,
  input logic                rst,
  input logic                mr_wr_en,
  input logic [DATA_W-1:0]   mr_wr_data,
  input logic                cke,
  input logic                rd_req,
  input logic                rd_ok,
  input logic                rd_accept,
  input logic                rd_reject,
  input logic [WR_CYC_W-1:0] wr_cycles,
  input logic                wr_bad,
  input logic [DATA_W-1:0]   mr_q
);

  localparam int RUN_W  = $clog2(LOCK_CYCLES + 1) + 1;
  localparam int WR_MSB = WR_LSB + WR_CODE_W - 1;
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_CYCLES);

  logic             start_w;
  logic [RUN_W-1:0] run;

  assign start_w = mr_wr_en && mr_wr_data[DLL_BIT];

  // Consecutive high clock-enable edges since the window last restarted.
  always_ff @(posedge clk) begin
    if (rst)
      run <= '0;
    else if (start_w)
      run <= '0;
    else if (!rd_ok)
      run <= cke ? run + RUN_W'(1) : '0;
  end

  // R2: the write lands in the register
  a_r2_write_stored: assert property (@(posedge clk) disable iff (rst)
    mr_wr_en |=> mr_q == $past(mr_wr_data));

  // R2: the request bit clears itself
  a_r2_self_clear: assert property (@(posedge clk) disable iff (rst)
    (mr_q[DLL_BIT] && !start_w) |=> !mr_q[DLL_BIT]);

  // R3: a request closes the read path
  a_r3_start_blocks: assert property (@(posedge clk) disable iff (rst)
    start_w |=> !rd_ok);

  // R4: the window lasts exactly the full count of high edges
  a_r4_lock_len: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_ok) |-> run == RUN_FULL);

  // R5: a low clock-enable never ends the window
  a_r5_cke_low_holds: assert property (@(posedge clk) disable iff (rst)
    (!rd_ok && !cke) |=> !rd_ok);

  // R6: recovery decode follows the written code
  a_r6_wr_decode: assert property (@(posedge clk) disable iff (rst)
    mr_wr_en |=> (wr_cycles == wr_code_to_cycles($past(mr_wr_data[WR_MSB:WR_LSB])))
                 && (wr_bad == ($past(mr_wr_data[WR_MSB:WR_LSB]) == '0)));

  // R7: blocked reads are refused
  a_r7_reject: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ok) |=> rd_reject && !rd_accept);

  // R8: allowed reads are accepted
  a_r8_accept: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ok) |=> rd_accept && !rd_reject);

  // R10: a plain write keeps reads allowed
  a_r10_plain_write: assert property (@(posedge clk) disable iff (rst)
    (mr_wr_en && !mr_wr_data[DLL_BIT] && rd_ok) |=> rd_ok);

endmodule

bind dll_lock_gate dll_lock_gate_chk #(
  .DATA_W     (DATA_W),
  .DLL_BIT    (DLL_BIT),
  .WR_LSB     (WR_LSB),
  .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mr_wr_en  (mr_wr_en),
  .mr_wr_data(mr_wr_data),
  .cke       (cke),
  .rd_req    (rd_req),
  .rd_ok     (rd_ok),
  .rd_accept (rd_accept),
  .rd_reject (rd_reject),
  .wr_cycles (wr_cycles),
  .wr_bad    (wr_bad),
  .mr_q      (mr_q)
);

// File: tb/tb_dll_lock_gate.sv
`timescale 1ns/1ps
module tb_dll_lock_gate;

  localparam int L  = 512;
  localparam int WD = 20000;
  localparam int K_RDOK = 0, K_ACC = 1, K_REJ = 2, K_MRQ = 3, K_WRC = 4, K_BAD = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mr_wr_en = 1'b0;
  logic [11:0] mr_wr_data = '0;
  logic        cke = 1'b1;
  logic        rd_req = 1'b0;
  logic        rd_ok, rd_accept, rd_reject, wr_bad;
  logic [3:0]  wr_cycles;
  logic [11:0] mr_q;

  dll_lock_gate #(.LOCK_CYCLES(L)) dut (
    .clk(clk), .rst(rst), .mr_wr_en(mr_wr_en), .mr_wr_data(mr_wr_data),
    .cke(cke), .rd_req(rd_req), .rd_ok(rd_ok), .rd_accept(rd_accept),
    .rd_reject(rd_reject), .wr_cycles(wr_cycles), .wr_bad(wr_bad), .mr_q(mr_q)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    kind;
    int    val;
    string req;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // Driver side: file an expectation for cycle cyc+d, kept in cycle order.
  task automatic expect_at(input int kind, input int val, input int d, input string req);
    item_t it;
    int    i;
    it.at = cyc + d; it.kind = kind; it.val = val; it.req = req;
    i = 0;
    while (i < q.size() && q[i].at <= it.at) i++;
    q.insert(i, it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int actual(input int kind);
    case (kind)
      K_RDOK:  return int'(rd_ok);
      K_ACC:   return int'(rd_accept);
      K_REJ:   return int'(rd_reject);
      K_MRQ:   return int'(mr_q);
      K_WRC:   return int'(wr_cycles);
      default: return int'(wr_bad);
    endcase
  endfunction

  function automatic int wr_ref(input int code);
    case (code)
      1: return 5;  2: return 6;  3: return 7;  4: return 8;
      5: return 10; 6: return 12; 7: return 14;
      default: return 0;
    endcase
  endfunction

  // Monitor side: compare each expectation at the falling edge of its cycle.
  item_t mon_it;
  int    mon_act;
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      mon_it  = q.pop_front();
      mon_act = actual(mon_it.kind);
      checks++;
      if (mon_it.at != cyc || mon_act != mon_it.val) begin
        errors++;
        $display("FAIL %s kind %0d cycle %0d actual %0h expected %0h",
                 mon_it.req, mon_it.kind, mon_it.at, mon_act, mon_it.val);
      end
    end
  end

  task automatic mr_write(input logic [11:0] d);
    mr_wr_en = 1'b1; mr_wr_data = d;
    tick();
    mr_wr_en = 1'b0;
  endtask

  task automatic read_pulse();
    rd_req = 1'b1;
    tick();
    rd_req = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) tick();
  endtask

  initial begin
    #(WD * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int c0, c1, c2;

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    expect_at(K_MRQ, 0, 0, "R1"); expect_at(K_RDOK, 1, 0, "R1");
    expect_at(K_ACC, 0, 0, "R1"); expect_at(K_REJ, 0, 0, "R1");
    expect_at(K_WRC, 0, 0, "R1"); expect_at(K_BAD, 1, 0, "R1");
    tick();

    // R2 / R10: plain write, code 3
    mr_write(12'h6A5);
    expect_at(K_MRQ, 'h6A5, 0, "R2"); expect_at(K_WRC, 7, 0, "R6");
    expect_at(K_BAD, 0, 0, "R6");     expect_at(K_RDOK, 1, 0, "R10");
    tick();
    expect_at(K_RDOK, 1, 0, "R10");

    // R8: read while allowed
    read_pulse();
    expect_at(K_ACC, 1, 0, "R8"); expect_at(K_REJ, 0, 0, "R8");
    tick();

    // R6: sweep of all codes
    for (int code = 0; code < 8; code++) begin
      mr_write(12'(code << 9));
      expect_at(K_WRC, wr_ref(code), 0, "R6");
      expect_at(K_BAD, (code == 0) ? 1 : 0, 0, "R6");
    end
    tick();

    // R3 / R2 / R4 / R7: DLL reset, full window with cke high
    cke = 1'b1;
    mr_write(12'hB00);
    c0 = cyc;
    expect_at(K_MRQ, 'hB00, 0, "R2"); expect_at(K_RDOK, 0, 0, "R3");
    expect_at(K_RDOK, 0, L - 1, "R4"); expect_at(K_RDOK, 1, L, "R4");
    tick();
    expect_at(K_MRQ, 'hA00, 0, "R2"); expect_at(K_WRC, 10, 0, "R2");
    read_pulse();
    expect_at(K_REJ, 1, 0, "R7"); expect_at(K_ACC, 0, 0, "R7");
    tick();
    expect_at(K_REJ, 0, 0, "R7"); expect_at(K_ACC, 0, 0, "R7");
    tick();
    expect_at(K_ACC, 0, 0, "R7");
    wait_until(c0 + L);
    read_pulse();
    expect_at(K_ACC, 1, 0, "R8"); expect_at(K_REJ, 0, 0, "R8");
    tick();

    // R5: clock-enable drop restarts the count
    mr_write(12'h300);
    c1 = cyc;
    wait_until(c1 + 100);
    cke = 1'b0;
    repeat (3) tick();
    cke = 1'b1;
    expect_at(K_RDOK, 0, (c1 + L) - cyc, "R5");
    expect_at(K_RDOK, 0, (c1 + 102 + L) - cyc, "R5");
    expect_at(K_RDOK, 1, (c1 + 103 + L) - cyc, "R5");
    wait_until(c1 + 105 + L);

    // R9: second request inside the window restarts it
    mr_write(12'h100);
    c2 = cyc;
    wait_until(c2 + 200);
    mr_write(12'h900);
    expect_at(K_RDOK, 0, 0, "R9");
    expect_at(K_RDOK, 0, (c2 + L) - cyc, "R9");
    expect_at(K_RDOK, 0, (c2 + 200 + L) - cyc, "R9");
    expect_at(K_RDOK, 1, (c2 + 201 + L) - cyc, "R9");
    wait_until(c2 + 203 + L);

    // R10: plain write after the window keeps reads allowed
    mr_write(12'h0C3);
    expect_at(K_RDOK, 1, 0, "R10"); expect_at(K_MRQ, 'h0C3, 0, "R10");
    tick();
    expect_at(K_RDOK, 1, 0, "R10");

    while (q.size() > 0) tick();
    tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule